// File: doc/BRIEF.md
# Serial configuration readback engine

This block reads a configuration word back out of a sensor over a two-wire bit-serial link. One line carries a clock that the engine drives, and the sensor shares that line with its detect output. The other line carries data from the sensor to the engine. A pulse on `start` makes the engine take the clock line as an output at the low level. It then produces one clock pulse per bit and samples the data line at the end of each high phase. The captured bits fill a word in ascending index order.

Bit 0 of the captured word is always stored as zero. After the last clock pulse the engine waits a settle interval. It then raises `done` for one cycle and compares the captured word with `ref_word`, which is the word the write side sent. All phase lengths are counted in ticks of a 1 µs enable input (`tick_us`), so a testbench can shorten them through the parameters without changing the sequence.

The states are named as follows. IDLE waits for `start`. PREP drives the clock line low for one cycle. HIGH holds the clock high for a half period and samples at its end. LOW holds the clock low for a half period. SETTLE waits out the settle interval. DONE reports the result. The transitions are:
- IDLE to PREP on `start`.
- PREP to HIGH unconditionally.
- HIGH to LOW when the half-period timer expires.
- LOW to HIGH on expiry while bits remain.
- LOW to SETTLE on expiry after the last bit.
- SETTLE to DONE on expiry.
- DONE to IDLE unconditionally.

Top module: `cfg_readback_engine`

## Requirements
- R1: After synchronous reset the engine is idle: `busy`, `done`, `mismatch`, `clk_line` and `clk_line_oe` are all low.
- R2: A `start` seen while idle makes `busy` and `clk_line_oe` high from the next cycle. `clk_line` stays low for at least that cycle before the first high phase, and `clk_line_oe` stays high while `busy` is high.
- R3: Each run produces exactly NBITS (48 by default) clock pulses on `clk_line`.
- R4: Every high phase and every low phase between pulses lasts exactly HALF_US ticks of `tick_us`.
- R5: The data level present at the end of the k-th high phase (k counted from 0) is stored in bit k of `rd_word`.
- R6: Bit 0 of `rd_word` is zero after every run, whatever level the data line had during the first pulse.
- R7: From the last falling edge of `clk_line` to `done`, exactly HALF_US + SETTLE_US ticks elapse. This is the final low phase followed by the settle interval.
- R8: `done` is high for exactly one cycle per run, and `busy` is low in the cycle after it.
- R9: `mismatch` is high only while `done` is high, and it is high exactly when `rd_word` differs from `ref_word` in any bit.
- R10: A `start` that arrives while `busy` is high has no effect. The run in progress still gives NBITS pulses and one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle enable every microsecond |
| start | input | 1 | Begin a readback run when idle |
| ref_word | input | NBITS | Word previously written, used for comparison |
| data_in | input | 1 | Serial data line from the sensor |
| clk_line | output | 1 | Level driven onto the shared clock line |
| clk_line_oe | output | 1 | High while the engine drives the clock line |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Compare failure, valid with `done` |
| rd_word | output | NBITS | Captured word, bit 0 forced to zero |

## Verification
The hardest situation to produce is a tick that lands in the very cycle a phase begins or ends, because that is where an off-by-one in the phase counter shows up. The bench drives `tick_us` from a seeded random pattern that includes back-to-back ticks, and it counts the ticks it sees in each phase at the ports. A second hard case is a sensor that answers with a 1 in bit 0 while the reference also carries a 1 there. Directed runs set exactly that case, so the forced-zero bit must itself produce the mismatch. Another directed run pulses `start` again in the middle of a run.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_HIGH,
        ST_LOW,
        ST_SETTLE,
        ST_DONE
    } rb_state_e;
endpackage

// File: rtl/cfgrb_tick_timer.sv
module cfgrb_tick_timer #(
    parameter int HALF_US   = 500,
    parameter int SETTLE_US = 30000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    input  logic long_sel,
    output logic expire
);
    localparam int MAXLEN = (HALF_US > SETTLE_US) ? HALF_US : SETTLE_US;
    localparam int CW     = $clog2(MAXLEN + 1);
    localparam logic [CW-1:0] HALF_LIM   = CW'(HALF_US - 1);
    localparam logic [CW-1:0] SETTLE_LIM = CW'(SETTLE_US - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit  = long_sel ? SETTLE_LIM : HALF_LIM;
    assign expire = run && tick && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || expire)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfgrb_capture.sv
module cfgrb_capture #(
    parameter int NBITS = 48
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     sample,
    input  logic [$clog2(NBITS)-1:0] idx,
    input  logic                     din,
    output logic [NBITS-1:0]         word
);
    localparam int IW = $clog2(NBITS);

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        if (b == 0) begin : g_zero
            always_ff @(posedge clk) begin
                word[b] <= 1'b0;
            end
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (rst || clr)
                    word[b] <= 1'b0;
                else if (sample && idx == IW'(b))
                    word[b] <= din;
            end
        end
    end
endmodule

// File: rtl/cfgrb_compare.sv
module cfgrb_compare #(
    parameter int NBITS = 48
) (
    input  logic [NBITS-1:0] got,
    input  logic [NBITS-1:0] want,
    output logic             differ
);
    assign differ = |(got ^ want);
endmodule

// File: rtl/cfg_readback_engine.sv
module cfg_readback_engine
    import cfgrb_pkg::*;
#(
    parameter int NBITS     = 48,
    parameter int HALF_US   = 500,
    parameter int SETTLE_US = 30000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_us,
    input  logic             start,
    input  logic [NBITS-1:0] ref_word,
    input  logic             data_in,
    output logic             clk_line,
    output logic             clk_line_oe,
    output logic             busy,
    output logic             done,
    output logic             mismatch,
    output logic [NBITS-1:0] rd_word
);
    localparam int IW = $clog2(NBITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(NBITS - 1);

    rb_state_e     state, state_nx;
    logic [IW-1:0] bit_idx;
    logic          expire;
    logic          run_timer;
    logic          long_sel;
    logic          differ;
    logic          take_bit;
    logic          clr_word;

    cfgrb_tick_timer #(
        .HALF_US   (HALF_US),
        .SETTLE_US (SETTLE_US)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_us),
        .run      (run_timer),
        .long_sel (long_sel),
        .expire   (expire)
    );

    cfgrb_capture #(
        .NBITS (NBITS)
    ) u_capture (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr_word),
        .sample (take_bit),
        .idx    (bit_idx),
        .din    (data_in),
        .word   (rd_word)
    );

    cfgrb_compare #(
        .NBITS (NBITS)
    ) u_compare (
        .got    (rd_word),
        .want   (ref_word),
        .differ (differ)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE)
            bit_idx <= '0;
        else if (state == ST_LOW && expire && bit_idx != LAST_IDX)
            bit_idx <= bit_idx + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_PREP;
            ST_PREP:   state_nx = ST_HIGH;
            ST_HIGH:   if (expire) state_nx = ST_LOW;
            ST_LOW: begin
                if (expire)
                    state_nx = (bit_idx == LAST_IDX) ? ST_SETTLE : ST_HIGH;
            end
            ST_SETTLE: if (expire) state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        clk_line    = 1'b0;
        clk_line_oe = 1'b1;
        busy        = 1'b1;
        done        = 1'b0;
        mismatch    = 1'b0;
        run_timer   = 1'b0;
        long_sel    = 1'b0;
        take_bit    = 1'b0;
        clr_word    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clk_line_oe = 1'b0;
                busy        = 1'b0;
                clr_word    = start;
            end
            ST_PREP: ;
            ST_HIGH: begin
                clk_line  = 1'b1;
                run_timer = 1'b1;
                take_bit  = expire;
            end
            ST_LOW:    run_timer = 1'b1;
            ST_SETTLE: begin
                run_timer = 1'b1;
                long_sel  = 1'b1;
            end
            ST_DONE: begin
                done     = 1'b1;
                mismatch = differ;
            end
            default: begin
                clk_line_oe = 1'b0;
                busy        = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cfg_readback_engine_chk.sv
module cfg_readback_engine_chk #(
    parameter int NBITS = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             clk_line,
    input logic             clk_line_oe,
    input logic             busy,
    input logic             done,
    input logic             mismatch,
    input logic [NBITS-1:0] rd_word
);
    p_idle_line_low_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!clk_line && !clk_line_oe && !done));

    p_start_takes_line_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && clk_line_oe && !clk_line));

    p_oe_while_busy_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> clk_line_oe);

    p_bit0_zero_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_word[0]);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_mismatch_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> done);

    p_no_clock_at_done_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !clk_line);
endmodule

bind cfg_readback_engine cfg_readback_engine_chk #(.NBITS(NBITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .clk_line    (clk_line),
    .clk_line_oe (clk_line_oe),
    .busy        (busy),
    .done        (done),
    .mismatch    (mismatch),
    .rd_word     (rd_word)
);

// File: tb/cfg_readback_engine_tb.sv
module cfg_readback_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 48;
    localparam int HALF = 3;
    localparam int SETL = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_us = 1'b0;
    logic          start = 1'b0;
    logic [NB-1:0] ref_word = '0;
    logic          data_in = 1'b0;
    logic          clk_line, clk_line_oe, busy, done, mismatch;
    logic [NB-1:0] rd_word;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int tick_mode = 0;

    logic [NB-1:0] src_vec = '0;
    int  pulses = 0, hi = 0, lo = 0, hi_bad = 0, lo_bad = 0, tail = 0, dones = 0;
    logic prev_line = 1'b0;
    logic mm_seen = 1'b0;
    logic [NB-1:0] word_seen = '0;

    cfg_readback_engine #(.NBITS(NB), .HALF_US(HALF), .SETTLE_US(SETL)) u_dut (
        .clk(clk), .rst(rst), .tick_us(tick_us), .start(start),
        .ref_word(ref_word), .data_in(data_in), .clk_line(clk_line),
        .clk_line_oe(clk_line_oe), .busy(busy), .done(done),
        .mismatch(mismatch), .rd_word(rd_word));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [NB-1:0] expect_word(logic [NB-1:0] v);
        return v & ~{{(NB-1){1'b0}}, 1'b1};
    endfunction

    function automatic logic [NB-1:0] rand_word();
        return {$urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // tick generator: mode 0 random sparse, 1 every cycle, 2 random dense
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cycles++;
            case (tick_mode)
                1:       tick_us = 1'b1;
                2:       tick_us = ($urandom % 4) != 0;
                default: tick_us = ($urandom % 3) == 0;
            endcase
        end
    end

    // sensor model and phase monitor
    initial begin
        forever begin
            @(negedge clk);
            if (clk_line && !prev_line) begin
                if (pulses > 0 && lo != HALF) lo_bad++;
                data_in = (pulses < NB) ? src_vec[pulses] : 1'b0;
                pulses++;
                hi = 0;
            end
            if (!clk_line && prev_line) begin
                if (hi != HALF) hi_bad++;
                lo = 0;
            end
            if (clk_line && tick_us) hi++;
            if (!clk_line && busy && !done && pulses > 0 && tick_us) lo++;
            if (done) begin
                tail      = lo;
                dones++;
                mm_seen   = mismatch;
                word_seen = rd_word;
            end
            prev_line = clk_line;
        end
    end

    initial begin
        if (cycles > 150000) ;
        forever begin
            @(posedge clk);
            if (cycles > 150000) begin
                chk(1'b0, "watchdog", 64'(cycles), 64'd150000);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

    task automatic run_one(input logic [NB-1:0] vec, input logic [NB-1:0] refw,
                           input bit restart_mid);
        logic [NB-1:0] exp;
        exp      = expect_word(vec);
        src_vec  = vec;
        ref_word = refw;
        pulses = 0; hi_bad = 0; lo_bad = 0; tail = 0; dones = 0;
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        @(negedge clk);
        chk(busy && clk_line_oe && !clk_line, "R2 start takes line low",
            64'({busy, clk_line_oe, clk_line}), 64'b110);
        if (restart_mid) begin
            repeat (40) @(posedge clk);
            #2 start = 1'b1;
            @(posedge clk); #2 start = 1'b0;
        end
        while (dones == 0) @(negedge clk);
        @(negedge clk);
        chk(!busy, "R8 busy low after done", 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        chk(dones == 1, "R8 one done pulse", 64'(dones), 64'd1);
        chk(pulses == NB, restart_mid ? "R10 restart ignored, pulse count" : "R3 pulse count",
            64'(pulses), 64'(NB));
        chk(hi_bad == 0 && lo_bad == 0, "R4 phase lengths", 64'(hi_bad + lo_bad), 64'd0);
        chk(tail == HALF + SETL, "R7 settle ticks", 64'(tail), 64'(HALF + SETL));
        chk(word_seen == exp, "R5 captured word", word_seen, exp);
        chk(word_seen[0] == 1'b0, "R6 bit0 forced", 64'(word_seen[0]), 64'd0);
        chk(mm_seen == (exp != refw), "R9 mismatch flag", 64'(mm_seen), 64'(exp != refw));
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !mismatch && !clk_line && !clk_line_oe,
            "R1 reset state", 64'({busy, done, mismatch, clk_line, clk_line_oe}), 64'd0);
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        chk(!busy && !clk_line_oe, "R1 idle after reset", 64'({busy, clk_line_oe}), 64'd0);

        // directed corners
        tick_mode = 1;
        run_one('0, '0, 1'b0);
        run_one('1, expect_word('1), 1'b0);
        run_one(48'h0000_0000_0001, 48'h0000_0000_0001, 1'b0);   // R6 bit0 forced -> mismatch
        tick_mode = 0;
        run_one(48'hA5A5_5A5A_F00F, expect_word(48'hA5A5_5A5A_F00F), 1'b1); // R10
        tick_mode = 2;
        run_one(48'h8000_0000_0000, 48'h0000_0000_0000, 1'b0);   // top bit mismatch

        // random runs
        for (int i = 0; i < 8; i++) begin
            logic [NB-1:0] v, r;
            tick_mode = i % 3;
            v = rand_word();
            r = expect_word(v);
            if (i % 2 == 1) r = r ^ (48'd1 << ($urandom % NB));
            run_one(v, r, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule